// File: doc/BRIEF.md
# Programmable-Format UART Transmitter

This block turns one character at a time into an asynchronous serial frame on a single TX line. A client offers a data byte with a valid/ready handshake. The block accepts the byte when it is idle and drops ready until the frame has been fully sent. All bit timing comes from a baud tick enable that pulses sixteen times per bit period. The block does not generate that tick itself.

A control byte sets the frame shape:

- the number of data bits, from five to eight;
- the number of stop bits;
- parity, which can be absent, odd, even, stuck at one or stuck at zero.

The transmitter captures the format and the byte at the moment it accepts a character, so the frame stays consistent even if the control byte changes in the middle of it. A separate break control in the same byte pulls the line low at once and holds it there. The break does not stop the serializer underneath, so frame timing carries on unchanged.

Top module: `uart_fmt_tx`

## Requirements
- R1: After synchronous reset, tx_line is 1, tx_ready is 1 and busy is 0.
- R2: Each frame has four parts, in this order:
  - one start bit of level 0;
  - the data bits, least significant bit first;
  - the parity bit, if enabled;
  - the stop time at level 1.

  ctrl[1:0] sets the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the word length are never sent.
- R3: Every bit lasts 16 ticks, and the stop time is sized by ctrl[2] and the word length:
  - ctrl[2]=0 gives 16 ticks;
  - ctrl[2]=1 with 5-bit words gives 24 ticks;
  - ctrl[2]=1 with 6, 7 or 8-bit words gives 32 ticks.

  A frame therefore occupies 16*(1+N+P)+S ticks, where N is the word length, P is 1 when a parity bit is sent and 0 otherwise, and S is the stop time.
- R4: With ctrl[3]=0, no parity bit is sent, and the stop time follows the last data bit directly.
- R5: With ctrl[3]=1 and ctrl[5]=0, the parity bit is computed over the N sent data bits only. ctrl[4]=0 gives odd parity: the data ones plus the parity bit make an odd count. ctrl[4]=1 gives even parity.
- R6: With ctrl[3]=1 and ctrl[5]=1, the parity bit is forced. It is 1 when ctrl[4]=0 and 0 when ctrl[4]=1.
- R7: While ctrl[6]=1, tx_line is 0 from the second clock edge after the bit is set. The frame in progress keeps its timing underneath the break. Once ctrl[6] is cleared, tx_line again shows the normal framing.
- R8: The format in ctrl[5:0] is captured when a character is accepted. Changing ctrl[5:0] during a frame has no effect on that frame.
- R9: A character is accepted on a clock edge where tx_valid and tx_ready are both 1. The next edge after acceptance drops tx_ready, and it stays low until the tick that ends the stop time. busy is the complement of tx_ready. A tx_valid that arrives while tx_ready is 0 is ignored.
- R10: Between frames, with no break requested, tx_line rests at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Baud enable, pulsing 16 times per bit period |
| ctrl | input | 8 | Frame format and break control byte |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Block can accept a character |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | A frame is in progress |

## Verification
The assertions check several behaviours on every cycle:
- the line stays high while idle with no break requested;
- the line is forced low under a break;
- an accepted character drops ready and produces a low start bit;
- the captured format does not move during a frame;
- the bit tick counter never passes its segment limit.

Only the bench scenarios can show the rest:
- the actual bit sequence, and its parity value for every combination of control bits;
- the exact frame length in ticks, including the 24-tick stop time;
- that mid-frame format changes and offers made while busy are ignored;
- that the stop level reappears after a break that covers part of a frame.

// File: rtl/uart_fmt_tx_pkg.sv
package uart_fmt_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } phase_t;

  // stop_code: 0 = one bit, 1 = one and a half bits, 2 = two bits
  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic       par_bit;
    logic [1:0] stop_code;
  } fmt_t;

endpackage

// File: rtl/uart_fmt_decode.sv
module uart_fmt_decode
  import uart_fmt_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 8
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DATA_W-1:0] data,
  output fmt_t              fmt
);

  logic [3:0] len;
  logic       ones_x;

  assign len = 4'd5 + {2'b00, ctrl[1:0]};

  always_comb begin
    ones_x = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(len)) ones_x = ones_x ^ data[i];
    end
  end

  always_comb begin
    fmt.nbits  = len;
    fmt.par_en = ctrl[3];
    // forced: ctrl[4]=0 -> mark, 1 -> space; else ctrl[4]=0 odd, 1 even
    fmt.par_bit = ctrl[5] ? ~ctrl[4] : (ctrl[4] ? ones_x : ~ones_x);
    if (!ctrl[2])          fmt.stop_code = 2'd0;
    else if (len == 4'd5)  fmt.stop_code = 2'd1;
    else                   fmt.stop_code = 2'd2;
  end

endmodule

// File: rtl/uart_fmt_bit_timer.sv
module uart_fmt_bit_timer #(
  parameter int TICKS_PER_BIT = 16,
  localparam int CW = $clog2(2 * TICKS_PER_BIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          seg_last
);

  logic [CW-1:0] cnt;

  assign seg_last = active && tick && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !active || seg_last) cnt <= '0;
    else if (tick)                  cnt <= cnt + CW'(1);
  end

  assert_cnt_in_segment_R3: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt < limit));

endmodule

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx
  import uart_fmt_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int CTRL_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_line,
  output logic              busy
);

  localparam int CW = $clog2(2 * TICKS_PER_BIT + 1);
  localparam logic [CW-1:0] LIM_BIT  = CW'(TICKS_PER_BIT);
  localparam logic [CW-1:0] LIM_1P5  = CW'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
  localparam logic [CW-1:0] LIM_2    = CW'(2 * TICKS_PER_BIT);

  phase_t            phase;
  fmt_t              fmt_dec, fmt_q;
  logic [DATA_W-1:0] shreg;
  logic [3:0]        bit_idx;
  logic [CW-1:0]     limit;
  logic              seg_last, accept, line_cur, brk;

  assign accept = tx_valid && tx_ready;
  assign brk    = ctrl[6];

  uart_fmt_decode #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_decode (
    .ctrl(ctrl), .data(tx_data), .fmt(fmt_dec)
  );

  always_comb begin
    if (phase == PH_STOP) begin
      case (fmt_q.stop_code)
        2'd1:    limit = LIM_1P5;
        2'd2:    limit = LIM_2;
        default: limit = LIM_BIT;
      endcase
    end else begin
      limit = LIM_BIT;
    end
  end

  uart_fmt_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk(clk), .rst(rst), .active(phase != PH_IDLE), .tick(tick16),
    .limit(limit), .seg_last(seg_last)
  );

  always_comb begin
    case (phase)
      PH_START: line_cur = 1'b0;
      PH_DATA:  line_cur = shreg[0];
      PH_PAR:   line_cur = fmt_q.par_bit;
      default:  line_cur = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      fmt_q    <= '0;
      shreg    <= '0;
      bit_idx  <= '0;
      tx_ready <= 1'b1;
      busy     <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          phase    <= PH_START;
          fmt_q    <= fmt_dec;
          shreg    <= tx_data;
          tx_ready <= 1'b0;
          busy     <= 1'b1;
        end
        PH_START: if (seg_last) begin
          phase   <= PH_DATA;
          bit_idx <= '0;
        end
        PH_DATA: if (seg_last) begin
          shreg   <= shreg >> 1;
          bit_idx <= bit_idx + 4'd1;
          if (bit_idx == fmt_q.nbits - 4'd1)
            phase <= fmt_q.par_en ? PH_PAR : PH_STOP;
        end
        PH_PAR: if (seg_last) phase <= PH_STOP;
        PH_STOP: if (seg_last) begin
          phase    <= PH_IDLE;
          tx_ready <= 1'b1;
          busy     <= 1'b0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tx_line <= 1'b1;
    else     tx_line <= brk ? 1'b0 : line_cur;
  end

  assert_idle_high_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && !brk) |=> tx_line);

  assert_break_low_R7: assert property (@(posedge clk) disable iff (rst)
    brk |=> !tx_line);

  assert_accept_drops_ready_R9: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!tx_ready && busy));

  assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> ##1 !tx_line);

  assert_fmt_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(fmt_q));

endmodule

// File: tb/uart_fmt_tx_test.sv
module uart_fmt_tx_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, tx_line, busy;

  int n_checks = 0;
  int n_fail   = 0;

  uart_fmt_tx uut (
    .clk(clk), .rst(rst), .tick16(tick16), .ctrl(ctrl), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line), .busy(busy)
  );

  always #10 clk = ~clk;

  initial begin : tick_gen
    int ph;
    ph = 0;
    forever begin
      @(posedge clk); #1;
      ph = (ph == 2) ? 0 : ph + 1;
      tick16 = (ph == 0);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Sends one frame, decodes it at mid-bit points and checks it.
  // brk_on/brk_off: tick counts at which ctrl[6] is set / cleared (0 = never)
  // alt_at: tick count at which ctrl[5:0] is overwritten with alt (0 = never)
  task automatic run_frame(input logic [7:0] c, input logic [7:0] d,
                           input int brk_on, input int brk_off,
                           input int alt_at, input logic [5:0] alt,
                           input logic offer_busy);
    int n, p, stop_t, total, cnt, brk_age, brk_bad;
    logic [15:0] bits;
    logic [7:0] dm, got;
    logic par_exp, x;
    n = 5 + int'(c[1:0]);
    p = c[3] ? 1 : 0;
    stop_t = !c[2] ? 16 : (n == 5 ? 24 : 32);
    total = 16 * (1 + n + p) + stop_t;
    dm = 8'h00;
    for (int i = 0; i < n; i++) dm[i] = d[i];
    x = ^dm;
    par_exp = c[5] ? ~c[4] : (c[4] ? x : ~x);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    @(posedge clk); #1;
    ctrl = c; tx_data = d; tx_valid = 1'b1;
    @(posedge clk); #1;
    tx_valid = 1'b0;
    cnt = 0; bits = '0; brk_age = -1; brk_bad = 0;
    @(negedge clk);
    check("R9 ready low after accept", {30'd0, tx_ready, busy}, 32'd1);
    while (!tx_ready) begin
      if (tick16) begin
        cnt++;
        for (int k = 0; k < 16; k++)
          if (cnt == 16 * k + 8) bits[k] = tx_line;
      end
      if (brk_age >= 2 && tx_line !== 1'b0) brk_bad++;
      if (brk_age >= 0) brk_age++;
      if (brk_on != 0 && cnt == brk_on && brk_age < 0) begin
        ctrl[6] = 1'b1; brk_age = 0;
      end
      if (brk_off != 0 && cnt == brk_off && brk_age >= 0) begin
        ctrl[6] = 1'b0; brk_age = -2;
      end
      if (alt_at != 0 && cnt == alt_at) ctrl[5:0] = alt;
      if (offer_busy && cnt == 30) begin
        tx_data = ~d; tx_valid = 1'b1;
      end else begin
        tx_valid = 1'b0;
      end
      @(negedge clk);
    end
    check("R3 frame length in ticks", cnt, total);
    if (brk_on != 0) begin
      check("R7 line low during break", brk_bad, 0);
      check("R7 stop level after break", {31'd0, bits[1 + n + p]}, 32'd1);
    end else begin
      got = 8'h00;
      for (int i = 0; i < n; i++) got[i] = bits[1 + i];
      check("R2 start bit", {31'd0, bits[0]}, 32'd0);
      check(alt_at != 0 ? "R8 data with format change" : "R2 data bits", got, dm);
      if (p == 1)
        check(c[5] ? "R6 forced parity" : "R5 odd/even parity",
              {31'd0, bits[1 + n]}, {31'd0, par_exp});
      else
        check("R4 no parity, stop follows data", {31'd0, bits[1 + n]}, 32'd1);
      check("R3 stop level", {31'd0, bits[1 + n + p]}, 32'd1);
    end
    ctrl[6] = 1'b0;
  endtask

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 reset tx_line", {31'd0, tx_line}, 32'd1);
    check("R1 reset tx_ready", {31'd0, tx_ready}, 32'd1);
    check("R1 reset busy", {31'd0, busy}, 32'd0);

    for (int c = 0; c < 64; c++)
      run_frame(8'(c), 8'((c * 73 + 29) & 255), 0, 0, 0, 6'd0, 1'b0);
    for (int c = 0; c < 64; c++)
      run_frame(8'(c), 8'((c * 151 + 200) & 255), 0, 0, 0, 6'd0, 1'b0);

    // R2 upper bits ignored: 5-bit words with all upper bits set
    run_frame(8'h08, 8'hE6, 0, 0, 0, 6'd0, 1'b0);
    // R8 mid-frame change of format: 5N1 frame, switched to 8 bits, parity, 2 stop
    run_frame(8'h00, 8'h15, 0, 0, 20, 6'h3F, 1'b0);
    run_frame(8'h3F, 8'hC3, 0, 0, 40, 6'h00, 1'b0);
    // R7 break over part of an 8N1 frame
    run_frame(8'h03, 8'h55, 20, 100, 0, 6'd0, 1'b0);

    // R9 offer while busy is ignored
    run_frame(8'h03, 8'h3C, 0, 0, 0, 6'd0, 1'b1);
    begin : idle_after
      int bad;
      bad = 0;
      repeat (200) begin
        @(negedge clk);
        if (tx_ready !== 1'b1 || tx_line !== 1'b1) bad++;
      end
      check("R9 offer while busy ignored", bad, 0);
      check("R10 idle line high", {31'd0, tx_line}, 32'd1);
    end

    // R7 break while idle
    @(posedge clk); #1 ctrl = 8'h43;
    @(negedge clk); @(negedge clk);
    check("R7 break while idle", {31'd0, tx_line}, 32'd0);
    @(posedge clk); #1 ctrl = 8'h03;
    @(negedge clk); @(negedge clk);
    check("R10 line high after break clears", {31'd0, tx_line}, 32'd1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : watchdog
    #(20 * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule